// File: doc/BRIEF.md
# Dark Reference Line Formatter

This block fills in the pixel content of the two shielded reference lines that the sensor's timing generator places in each frame, one ahead of the image rows and one after them. For every pixel slot the timing generator presents a column index and a flag saying that the current line is a reference line. The formatter answers, one clock later, with a segment code and a 10-bit test value. A downstream stage uses the code to tell apart a light-shielded pixel, a red, green or blue calibration pixel, and a pixel with no colour filter.

The 644-column reference line has a fixed layout. Eight calibration groups of 13 pixels come first: shielded, red, green, blue, unfiltered, then three more shielded groups. A run of 540 shielded pixels fills the rest of the line. The layout is held in a package table, and elaboration fails if its total is not the line length. Each segment kind has its own 10-bit value supplied on an input port, so a bench can see where every segment starts and ends. In monochrome mode the three colour groups are reported as unfiltered. While the flag is low, or once the column goes past the end of the line, the outputs are zero.

Top module: `dkline_fmt`

## Requirements
- R1: When `dark_line` is low at a rising edge, `seg_code` is 0 (none) and `pix_val` is 0 after that edge.
- R2: With `dark_line` high, columns 0..12 and 65..103 give `seg_code` 1 (shielded) and `pix_val` equal to `val_dark`.
- R3: With `dark_line` high and `mono` low, columns 13..25 give `seg_code` 2 (red) and `pix_val` equal to `val_red`.
- R4: With `dark_line` high and `mono` low, columns 26..38 give `seg_code` 3 (green) and `pix_val` equal to `val_green`.
- R5: With `dark_line` high and `mono` low, columns 39..51 give `seg_code` 4 (blue) and `pix_val` equal to `val_blue`.
- R6: With `dark_line` high, columns 52..64 give `seg_code` 5 (unfiltered) and `pix_val` equal to `val_open`.
- R7: With `dark_line` high, columns 104..643 (the 540-pixel run) give `seg_code` 1 and `pix_val` equal to `val_dark`.
- R8: With `dark_line` high, a column of 644 or more gives `seg_code` 0 and `pix_val` 0.
- R9: With `dark_line` and `mono` both high, columns 13..51 give `seg_code` 5 and `pix_val` equal to `val_open`. No colour code (2, 3 or 4) ever appears in monochrome mode.
- R10: The outputs show the inputs sampled at the previous rising edge, and those inputs include the value ports. The latency is exactly one clock.
- R11: While `rst_n` is low, `seg_code` and `pix_val` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dark_line | input | 1 | High while the current line is a reference line |
| mono | input | 1 | Monochrome mode: colour groups reported as unfiltered |
| col_idx | input | 10 | Column index of the current pixel slot |
| val_dark | input | 10 | Output value for shielded pixels |
| val_red | input | 10 | Output value for red calibration pixels |
| val_green | input | 10 | Output value for green calibration pixels |
| val_blue | input | 10 | Output value for blue calibration pixels |
| val_open | input | 10 | Output value for unfiltered pixels |
| seg_code | output | 3 | Segment code, registered |
| pix_val | output | 10 | Test value, registered |

## Verification
The monochrome remap and the colour-group decode can both act on the same pixel in the same cycle. A column inside 13..51 with `mono` high asks for both at once, and the remap must win. The bench provokes this with random column, `mono` and flag values, and again with directed columns at every group edge under both settings. Each result is judged against a bench function that derives the code from the column range first and then applies the monochrome rule. The line-end limit and the flag gate meet in the same way at columns 644 and above. Those cases are judged to give zero whatever the other inputs are.

// File: rtl/dkline_pkg.sv
package dkline_pkg;

    localparam int LINE_LEN  = 644;
    localparam int GRP_LEN   = 13;
    localparam int N_GRP     = 8;
    localparam int RUN_LEN   = 540;
    localparam int COL_W     = 10;
    localparam int VAL_W     = 10;
    localparam int CODE_W    = 3;
    localparam int RUN_START = N_GRP * GRP_LEN;
    localparam int RUN_END   = RUN_START + RUN_LEN;

    typedef enum logic [CODE_W-1:0] {
        SEG_NONE  = 3'd0,
        SEG_DARK  = 3'd1,
        SEG_RED   = 3'd2,
        SEG_GREEN = 3'd3,
        SEG_BLUE  = 3'd4,
        SEG_OPEN  = 3'd5
    } seg_kind_e;

    localparam seg_kind_e GRP_ORDER [0:N_GRP-1] = '{
        SEG_DARK, SEG_RED, SEG_GREEN, SEG_BLUE,
        SEG_OPEN, SEG_DARK, SEG_DARK, SEG_DARK
    };

endpackage

// File: rtl/dkline_seg_decode.sv
module dkline_seg_decode
    import dkline_pkg::*;
#(
    parameter int P_COL_W   = COL_W,
    parameter int P_GRP_LEN = GRP_LEN,
    parameter int P_N_GRP   = N_GRP,
    parameter int P_RUN_LEN = RUN_LEN,
    parameter int P_LINE    = LINE_LEN
) (
    input  logic [P_COL_W-1:0] col_idx,
    output seg_kind_e          kind
);

    localparam int L_RUN_START = P_N_GRP * P_GRP_LEN;
    localparam int L_RUN_END   = L_RUN_START + P_RUN_LEN;

    generate
        if (L_RUN_END != P_LINE) begin : g_len_bad
            $error("segment table total does not match the line length");
        end
    endgenerate

    logic [P_N_GRP-1:0] grp_hit;
    logic               run_hit;
    int                 col_i;

    assign col_i = int'(col_idx);

    genvar gi;
    generate
        for (gi = 0; gi < P_N_GRP; gi++) begin : g_grp
            assign grp_hit[gi] = (col_i >= gi * P_GRP_LEN) &&
                                 (col_i <  (gi + 1) * P_GRP_LEN);
        end
    endgenerate

    assign run_hit = (col_i >= L_RUN_START) && (col_i < L_RUN_END);

    always_comb begin
        kind = SEG_NONE;
        for (int k = 0; k < P_N_GRP; k++) begin
            if (grp_hit[k]) kind = GRP_ORDER[k];
        end
        if (run_hit) kind = SEG_DARK;
    end

endmodule

// File: rtl/dkline_val_sel.sv
module dkline_val_sel
    import dkline_pkg::*;
#(
    parameter int P_VAL_W = VAL_W
) (
    input  logic               active,
    input  logic               mono,
    input  seg_kind_e          kind_in,
    input  logic [P_VAL_W-1:0] val_dark,
    input  logic [P_VAL_W-1:0] val_red,
    input  logic [P_VAL_W-1:0] val_green,
    input  logic [P_VAL_W-1:0] val_blue,
    input  logic [P_VAL_W-1:0] val_open,
    output seg_kind_e          kind_out,
    output logic [P_VAL_W-1:0] val_out
);

    seg_kind_e kind_m;

    always_comb begin
        kind_m = active ? kind_in : SEG_NONE;
        if (mono && (kind_m == SEG_RED || kind_m == SEG_GREEN || kind_m == SEG_BLUE))
            kind_m = SEG_OPEN;
    end

    always_comb begin
        kind_out = kind_m;
        unique case (kind_m)
            SEG_DARK:  val_out = val_dark;
            SEG_RED:   val_out = val_red;
            SEG_GREEN: val_out = val_green;
            SEG_BLUE:  val_out = val_blue;
            SEG_OPEN:  val_out = val_open;
            default:   val_out = '0;
        endcase
    end

endmodule

// File: rtl/dkline_fmt.sv
module dkline_fmt
    import dkline_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dark_line,
    input  logic              mono,
    input  logic [COL_W-1:0]  col_idx,
    input  logic [VAL_W-1:0]  val_dark,
    input  logic [VAL_W-1:0]  val_red,
    input  logic [VAL_W-1:0]  val_green,
    input  logic [VAL_W-1:0]  val_blue,
    input  logic [VAL_W-1:0]  val_open,
    output logic [CODE_W-1:0] seg_code,
    output logic [VAL_W-1:0]  pix_val
);

    seg_kind_e           kind_raw;
    seg_kind_e           kind_fin;
    logic [VAL_W-1:0]    val_fin;

    dkline_seg_decode #(
        .P_COL_W   (COL_W),
        .P_GRP_LEN (GRP_LEN),
        .P_N_GRP   (N_GRP),
        .P_RUN_LEN (RUN_LEN),
        .P_LINE    (LINE_LEN)
    ) u_decode (
        .col_idx (col_idx),
        .kind    (kind_raw)
    );

    dkline_val_sel #(
        .P_VAL_W (VAL_W)
    ) u_sel (
        .active    (dark_line),
        .mono      (mono),
        .kind_in   (kind_raw),
        .val_dark  (val_dark),
        .val_red   (val_red),
        .val_green (val_green),
        .val_blue  (val_blue),
        .val_open  (val_open),
        .kind_out  (kind_fin),
        .val_out   (val_fin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_code <= '0;
            pix_val  <= '0;
        end else begin
            seg_code <= kind_fin;
            pix_val  <= val_fin;
        end
    end

endmodule

// File: rtl/dkline_fmt_chk.sv
module dkline_fmt_chk
    import dkline_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dark_line,
    input logic              mono,
    input logic [COL_W-1:0]  col_idx,
    input logic [VAL_W-1:0]  val_dark,
    input logic [VAL_W-1:0]  val_red,
    input logic [VAL_W-1:0]  val_green,
    input logic [VAL_W-1:0]  val_blue,
    input logic [VAL_W-1:0]  val_open,
    input logic [CODE_W-1:0] seg_code,
    input logic [VAL_W-1:0]  pix_val
);

    assert_flag_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dark_line |=> (seg_code == '0) && (pix_val == '0));

    assert_first_group_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dark_line && int'(col_idx) < GRP_LEN)
        |=> (seg_code == 3'd1) && (pix_val == $past(val_dark)));

    assert_open_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dark_line && int'(col_idx) >= 4*GRP_LEN && int'(col_idx) < 5*GRP_LEN)
        |=> (seg_code == 3'd5) && (pix_val == $past(val_open)));

    assert_past_end_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(col_idx) >= LINE_LEN) |=> (seg_code == '0) && (pix_val == '0));

    assert_mono_no_colour_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mono |=> (seg_code != 3'd2) && (seg_code != 3'd3) && (seg_code != 3'd4));

endmodule

bind dkline_fmt dkline_fmt_chk u_chk (.*);

// File: tb/dkline_fmt_bench.sv
`timescale 1ns/100ps
module dkline_fmt_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dark_line, mono;
    logic [9:0] col_idx;
    logic [9:0] val_dark, val_red, val_green, val_blue, val_open;
    logic [2:0] seg_code;
    logic [9:0] pix_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    dkline_fmt u_dkline_fmt (
        .clk(clk), .rst_n(rst_n), .dark_line(dark_line), .mono(mono),
        .col_idx(col_idx), .val_dark(val_dark), .val_red(val_red),
        .val_green(val_green), .val_blue(val_blue), .val_open(val_open),
        .seg_code(seg_code), .pix_val(pix_val)
    );

    function automatic logic [2:0] ref_code(logic f, logic m, int c);
        logic [2:0] r;
        if (!f || c >= 644)  r = 3'd0;
        else if (c < 13)     r = 3'd1;
        else if (c < 26)     r = 3'd2;
        else if (c < 39)     r = 3'd3;
        else if (c < 52)     r = 3'd4;
        else if (c < 65)     r = 3'd5;
        else                 r = 3'd1;
        if (m && (r == 3'd2 || r == 3'd3 || r == 3'd4)) r = 3'd5;
        return r;
    endfunction

    function automatic string ref_tag(logic f, logic m, int c);
        if (!f)                      return "R1";
        if (c >= 644)                return "R8";
        if (m && c >= 13 && c < 52)  return "R9";
        if (c < 13 || (c >= 65 && c < 104)) return "R2";
        if (c < 26)  return "R3";
        if (c < 39)  return "R4";
        if (c < 52)  return "R5";
        if (c < 65)  return "R6";
        return "R7";
    endfunction

    function automatic logic [9:0] ref_val(logic [2:0] k);
        case (k)
            3'd1: return val_dark;
            3'd2: return val_red;
            3'd3: return val_green;
            3'd4: return val_blue;
            3'd5: return val_open;
            default: return 10'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [2:0] ec, logic [9:0] ev);
        n_chk++;
        if (seg_code !== ec || pix_val !== ev) begin
            n_bad++;
            $display("FAIL %s: code=%0d val=%0d expected code=%0d val=%0d",
                     tag, seg_code, pix_val, ec, ev);
        end
    endtask

    // drive at negedge, check at the next negedge (one register: R10)
    task automatic apply(logic f, logic m, int c);
        logic [2:0] ec;
        logic [9:0] ev;
        string      tg;
        dark_line = f; mono = m; col_idx = 10'(c);
        ec = ref_code(f, m, c);
        ev = ref_val(ec);
        tg = ref_tag(f, m, c);
        @(negedge clk);
        check(tg, ec, ev);
    endtask

    task automatic new_vals();
        val_dark  = 10'($urandom);
        val_red   = 10'($urandom);
        val_green = 10'($urandom);
        val_blue  = 10'($urandom);
        val_open  = 10'($urandom);
    endtask

    initial begin
        int edges [] = '{0, 12, 13, 25, 26, 38, 39, 51, 52, 64, 65,
                         103, 104, 643, 644, 1023};
        void'($urandom(32'd8787));
        rst_n = 1'b0; dark_line = 1'b1; mono = 1'b0; col_idx = 10'd20;
        new_vals();
        repeat (3) @(negedge clk);
        check("R11", 3'd0, 10'd0);
        rst_n = 1'b1;

        for (int mi = 0; mi < 2; mi++) begin
            foreach (edges[i]) apply(1'b1, 1'(mi), edges[i]);
        end
        apply(1'b0, 1'b0, 20);
        apply(1'b0, 1'b1, 0);

        // R10: value port change takes effect in the same cycle's sample
        apply(1'b1, 1'b0, 30);
        val_green = ~val_green;
        apply(1'b1, 1'b0, 30);

        // full line sweep, both modes
        for (int mi = 0; mi < 2; mi++) begin
            for (int c = 0; c < 650; c++) apply(1'b1, 1'(mi), c);
        end

        for (int n = 0; n < 4000; n++) begin
            if (n % 97 == 0) new_vals();
            apply(($urandom % 4) != 0, 1'($urandom), int'($urandom % 1024));
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule